// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits next to the command decoder of a serial NOR flash. It keeps the write-enable latch and the protection fields of the status register: a sticky status-lock bit and a three-bit block-protect code. It decides whether a status-register write, a program command or an erase command may run. The decoder gives it one command strobe per cycle, the target address, the new status fields and the level of the active-low write-protect pin. The block answers with a one-cycle accept or reject pulse.

Status writes are gated in two ways. The status-lock bit on its own has no effect. When it is set and the write-protect pin is low, the device is in hardware-protected mode and every status write is refused until the pin returns high. Program and erase commands are checked against a region at the top of a 2 MiB space. That space is 32 blocks of 64 KiB, and the region is chosen by the block-protect code. Chip erase only runs when nothing is protected.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, the status-lock bit is 0, the block-protect code is 000, the write-enable latch is 0, and both accept and reject are 0.
- R2: A write-enable strobe sets the latch. A write-disable strobe clears it. The latch state is visible on `wel` one cycle after the strobe.
- R3: While the status-lock bit is 0, a status write with the latch set is accepted at either pin level. It loads `new_lock` into the status-lock bit and `new_bp` into the block-protect code.
- R4: While the status-lock bit is 1 and `wp_n` is high, a status write with the latch set is accepted and loads the new fields.
- R5: While the status-lock bit is 1 and `wp_n` is low, every status write is rejected, even with the latch set, and the status fields keep their values.
- R6: `hw_protected` is high exactly while the status-lock bit is 1 and `wp_n` is low. It is entered in either order: setting the bit while the pin is low, or pulling the pin low after the bit is set. It is left only by driving `wp_n` high.
- R7: Page program, dual-input program, sector erase and block erase are rejected when address block `addr[20:16]` falls in the protected region, and accepted otherwise when the latch is set. The protected region for each code is:
  - code 0: nothing is protected;
  - code k from 1 to 5: blocks numbered 32 − 2^(k−1) and above;
  - codes 6 and 7: every block.
- R8: Chip erase is accepted only when the block-protect code is 000 and the latch is set. Otherwise it is rejected.
- R9: Any status write, program or erase command issued while the latch is clear is rejected, and `cmd_reject` is high for that one cycle only.
- R10: The latch is clear after any status write, program or erase command, whether that command was accepted or rejected.
- R11: Accept and reject are registered. They appear in the cycle after the strobe, never together, and stay low when no write-type command was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| cmd_pp | input | 1 | Page program strobe |
| cmd_dpp | input | 1 | Dual-input program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Block erase strobe |
| cmd_ce | input | 1 | Chip erase strobe |
| addr | input | ADDR_W | Target byte address of a program or erase |
| new_lock | input | 1 | Status-lock value carried by a status write |
| new_bp | input | 3 | Block-protect code carried by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_accept | output | 1 | One-cycle pulse: the command may run |
| cmd_reject | output | 1 | One-cycle pulse: the command is refused |
| sr_lock | output | 1 | Current status-lock bit |
| sr_bp | output | 3 | Current block-protect code |
| wel | output | 1 | Write-enable latch |
| hw_protected | output | 1 | Hardware-protected mode indication |

## Verification
The address check is swept in full. For each of the eight protect codes, all 32 blocks are hit by each of the four region-checked commands, followed by a chip erase. This separates an off-by-one region boundary, a wrong code-to-size mapping and a chip erase that ignores the code. Status writes are tried for every combination of lock bit, pin level and latch state. Both ways of entering hardware-protected mode are exercised, and so is leaving it by raising the pin. Commands issued with the latch clear show whether rejection depends only on the latch and whether it lasts exactly one cycle.

// File: rtl/flash_wp_pkg.sv
// Package: shared types and constants for the write-protection controller.
// Assumes a 3-bit block-protect code.
package flash_wp_pkg;
    localparam int BP_W = 3;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } wp_status_t;
endpackage

// File: rtl/fwp_wel_latch.sv
// Module: write-enable latch.
// A clear request wins over a set request. Assumes the decoder raises at
// most one command strobe per cycle.
module fwp_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    // Purpose: hold the latch, with clear taking priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_o <= 1'b0;
        else if (clr_i)
            wel_o <= 1'b0;
        else if (set_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/fwp_status_reg.sv
// Module: protection fields of the status register.
// Loads only on an approved status write. Resets to the unprotected state.
module fwp_status_reg
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_i,
    input  wp_status_t d_i,
    output wp_status_t q_o
);
    // Purpose: keep the lock bit and the block-protect code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (ld_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/fwp_region_dec.sv
// Module: maps the block-protect code and a byte address to a
// "protected" flag.
// Code 0 protects nothing. Code k protects the top 2^(k-1) blocks, and a
// code that reaches or passes the full array protects all of it.
// Assumes the protected region grows downward from the top address.
module fwp_region_dec #(
    parameter int ADDR_W    = 21,
    parameter int BLK_LOG2  = 16,
    parameter int NBLK_LOG2 = 5,
    parameter int BP_W      = 3
) (
    input  logic [BP_W-1:0]   bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o,
    output logic              any_prot_o
);
    localparam int NCODE = 1 << BP_W;
    localparam int NBLK  = 1 << NBLK_LOG2;

    logic [NCODE-1:0] hit;

    // One comparator per code value, each against its own lower bound.
    genvar g;
    generate
        for (g = 0; g < NCODE; g++) begin : g_code
            if (g == 0) begin : g_none
                assign hit[g] = 1'b0;
            end else if ((g - 1) >= NBLK_LOG2) begin : g_all
                assign hit[g] = 1'b1;
            end else begin : g_top
                localparam longint unsigned LIM_BLK  = longint'(NBLK - (1 << (g - 1)));
                localparam longint unsigned LIM_ADDR = LIM_BLK << BLK_LOG2;
                assign hit[g] = (addr_i >= LIM_ADDR[ADDR_W-1:0]);
            end
        end
    endgenerate

    // Purpose: pick the comparator result for the current code.
    always_comb begin
        prot_o     = hit[bp_i];
        any_prot_o = (bp_i != '0);
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
// Module: top of the write-protection controller.
// Takes decoded command strobes (at most one per cycle), keeps the latch and
// the status protection fields, and returns a registered one-cycle accept or
// reject for every status write, program or erase.
// wp_n is assumed to be already synchronised to clk.
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int BLK_LOG2  = 16,
    parameter int NBLK_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_dpp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic [ADDR_W-1:0] addr,
    input  logic              new_lock,
    input  logic [2:0]        new_bp,
    input  logic              wp_n,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              sr_lock,
    output logic [2:0]        sr_bp,
    output logic              wel,
    output logic              hw_protected
);
    wp_status_t st_q;
    wp_status_t st_d;
    logic       prot;
    logic       any_prot;
    logic       region_op;
    logic       write_op;
    logic       sr_locked;
    logic       wrsr_ok;
    logic       region_ok;
    logic       chip_ok;
    logic       approve;

    fwp_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cmd_wren),
        .clr_i (cmd_wrdi | write_op),
        .wel_o (wel)
    );

    fwp_region_dec #(
        .ADDR_W    (ADDR_W),
        .BLK_LOG2  (BLK_LOG2),
        .NBLK_LOG2 (NBLK_LOG2),
        .BP_W      (BP_W)
    ) u_region (
        .bp_i       (st_q.bp),
        .addr_i     (addr),
        .prot_o     (prot),
        .any_prot_o (any_prot)
    );

    fwp_status_reg u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_i  (wrsr_ok),
        .d_i   (st_d),
        .q_o   (st_q)
    );

    // Purpose: decide, per command, whether it is allowed to run.
    always_comb begin
        region_op  = cmd_pp | cmd_dpp | cmd_se | cmd_be;
        write_op   = cmd_wrsr | region_op | cmd_ce;
        sr_locked  = st_q.lock & ~wp_n;
        wrsr_ok    = cmd_wrsr & wel & ~sr_locked;
        region_ok  = region_op & wel & ~prot;
        chip_ok    = cmd_ce & wel & ~any_prot;
        approve    = wrsr_ok | region_ok | chip_ok;
        st_d.lock  = new_lock;
        st_d.bp    = new_bp;
    end

    // Purpose: register the verdict as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= write_op & approve;
            cmd_reject <= write_op & ~approve;
        end
    end

    // Purpose: drive the status outputs and the hardware-protection flag.
    always_comb begin
        sr_lock      = st_q.lock;
        sr_bp        = st_q.bp;
        hw_protected = st_q.lock & ~wp_n;
    end
endmodule

// File: rtl/fwp_checker.sv
// Module: temporal checks on the controller's ports. Bound into every
// flash_wp_ctrl instance below.
module fwp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_dpp,
    input logic       cmd_se,
    input logic       cmd_be,
    input logic       cmd_ce,
    input logic       wp_n,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic       sr_lock,
    input logic [2:0] sr_bp,
    input logic       wel,
    input logic       hw_protected
);
    logic any_op;
    assign any_op = cmd_wrsr | cmd_pp | cmd_dpp | cmd_se | cmd_be | cmd_ce;

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !any_op && !cmd_wrdi) |=> wel);

    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrdi |=> !wel);

    a_r3_status_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sr_lock, sr_bp}) |-> ($past(cmd_wrsr) && $past(wel)));

    a_r5_locked_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && sr_lock && !wp_n) |=> (cmd_reject && $stable(sr_lock) && $stable(sr_bp)));

    a_r6_pin_high_exits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wp_n) |-> !hw_protected);

    a_r8_chip_erase_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ce && sr_bp != 3'd0) |=> cmd_reject);

    a_r9_no_latch_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (any_op && !wel) |=> (cmd_reject && !cmd_accept));

    a_r10_latch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        any_op |=> !wel);

    a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op |=> (!cmd_accept && !cmd_reject));
endmodule

bind flash_wp_ctrl fwp_checker u_fwp_checker (.*);

// File: tb/flash_wp_ctrl_tb_top.sv
// Bench: sweeps status writes over lock/pin/latch combinations, and every
// protect code against every block for each region-checked command.
module flash_wp_ctrl_tb_top;
    localparam int ADDR_W = 21;

    localparam int K_WREN = 0;
    localparam int K_WRDI = 1;
    localparam int K_WRSR = 2;
    localparam int K_PP   = 3;
    localparam int K_DPP  = 4;
    localparam int K_SE   = 5;
    localparam int K_BE   = 6;
    localparam int K_CE   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_wren = 1'b0;
    logic              cmd_wrdi = 1'b0;
    logic              cmd_wrsr = 1'b0;
    logic              cmd_pp = 1'b0;
    logic              cmd_dpp = 1'b0;
    logic              cmd_se = 1'b0;
    logic              cmd_be = 1'b0;
    logic              cmd_ce = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              new_lock = 1'b0;
    logic [2:0]        new_bp = 3'd0;
    logic              wp_n = 1'b1;
    logic              cmd_accept;
    logic              cmd_reject;
    logic              sr_lock;
    logic [2:0]        sr_bp;
    logic              wel;
    logic              hw_protected;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_wp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_pp(cmd_pp), .cmd_dpp(cmd_dpp), .cmd_se(cmd_se),
        .cmd_be(cmd_be), .cmd_ce(cmd_ce), .addr(addr),
        .new_lock(new_lock), .new_bp(new_bp), .wp_n(wp_n),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .sr_lock(sr_lock), .sr_bp(sr_bp), .wel(wel),
        .hw_protected(hw_protected)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse one strobe for a cycle. Returns at the next negedge, where the
    // registered verdict is visible.
    task automatic issue(input int kind, input logic [ADDR_W-1:0] a,
                         input logic lk, input logic [2:0] bp);
        @(negedge clk);
        addr = a; new_lock = lk; new_bp = bp;
        cmd_wren = (kind == K_WREN); cmd_wrdi = (kind == K_WRDI);
        cmd_wrsr = (kind == K_WRSR); cmd_pp   = (kind == K_PP);
        cmd_dpp  = (kind == K_DPP);  cmd_se   = (kind == K_SE);
        cmd_be   = (kind == K_BE);   cmd_ce   = (kind == K_CE);
        @(negedge clk);
        {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_dpp, cmd_se, cmd_be, cmd_ce} = '0;
    endtask

    task automatic set_status(input logic lk, input logic [2:0] bp);
        wp_n = 1'b1;
        issue(K_WREN, '0, 1'b0, 3'd0);
        issue(K_WRSR, '0, lk, bp);
    endtask

    function automatic bit exp_prot(input int code, input int blk);
        if (code == 0) return 1'b0;
        if (code >= 6) return 1'b1;
        return blk >= (32 - (1 << (code - 1)));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lock", sr_lock, 0);
        chk("R1 bp", sr_bp, 0);
        chk("R1 wel", wel, 0);
        chk("R1 accept", cmd_accept, 0);
        chk("R1 reject", cmd_reject, 0);

        // R2 latch set and clear
        issue(K_WREN, '0, 0, 0);
        chk("R2 wren sets", wel, 1);
        issue(K_WRDI, '0, 0, 0);
        chk("R2 wrdi clears", wel, 0);

        // R9 commands without the latch
        for (int k = K_WRSR; k <= K_CE; k++) begin
            issue(k, '0, 1, 3'd5);
            chk("R9 reject no latch", cmd_reject, 1);
            chk("R9 no accept", cmd_accept, 0);
            @(negedge clk);
            chk("R9 one-cycle pulse", cmd_reject, 0);
        end
        chk("R9 status untouched", {sr_lock, sr_bp}, 0);

        // R3 unlocked status writes at both pin levels
        for (int v = 0; v < 16; v++) begin
            wp_n = v[0];
            issue(K_WREN, '0, 0, 0);
            issue(K_WRSR, '0, 1'b0, v[3:1]);
            chk("R3 accept", cmd_accept, 1);
            chk("R3 bp loaded", sr_bp, v[3:1]);
            chk("R10 latch dropped", wel, 0);
        end

        // R4 locked, pin high: writes still allowed
        set_status(1'b1, 3'd2);
        chk("R3 lock loaded", sr_lock, 1);
        issue(K_WREN, '0, 0, 0);
        issue(K_WRSR, '0, 1'b1, 3'd6);
        chk("R4 accept", cmd_accept, 1);
        chk("R4 bp", sr_bp, 6);

        // R5/R6 pin pulled low after lock set
        @(negedge clk); wp_n = 1'b0; #1;
        chk("R6 enter by pin", hw_protected, 1);
        issue(K_WREN, '0, 0, 0);
        issue(K_WRSR, '0, 1'b0, 3'd1);
        chk("R5 reject", cmd_reject, 1);
        chk("R5 lock kept", sr_lock, 1);
        chk("R5 bp kept", sr_bp, 6);
        chk("R10 latch dropped", wel, 0);
        @(negedge clk); wp_n = 1'b1; #1;
        chk("R6 exit by pin", hw_protected, 0);

        // R6 other order: pin low first, then lock set
        set_status(1'b0, 3'd0);
        @(negedge clk); wp_n = 1'b0; #1;
        chk("R6 not yet", hw_protected, 0);
        issue(K_WREN, '0, 0, 0);
        issue(K_WRSR, '0, 1'b1, 3'd0);
        chk("R3 accept pin low", cmd_accept, 1);
        #1;
        chk("R6 enter by lock", hw_protected, 1);
        @(negedge clk); wp_n = 1'b1; #1;
        chk("R6 exit", hw_protected, 0);

        // R7/R8 full region sweep
        for (int code = 0; code < 8; code++) begin
            set_status(1'b0, code[2:0]);
            for (int blk = 0; blk < 32; blk++) begin
                for (int k = K_PP; k <= K_BE; k++) begin
                    logic [ADDR_W-1:0] a;
                    a = {blk[4:0], 16'(blk * 16'h1357 + k)};
                    issue(K_WREN, '0, 0, 0);
                    issue(k, a, 0, 0);
                    chk("R7 accept", cmd_accept, !exp_prot(code, blk));
                    chk("R7 reject", cmd_reject, exp_prot(code, blk));
                end
            end
            issue(K_WREN, '0, 0, 0);
            issue(K_CE, '0, 0, 0);
            chk("R8 chip erase accept", cmd_accept, code == 0);
            chk("R8 chip erase reject", cmd_reject, code != 0);
            chk("R10 latch dropped", wel, 0);
        end

        // R11 idle cycle stays quiet
        @(negedge clk);
        chk("R11 idle accept", cmd_accept, 0);
        chk("R11 idle reject", cmd_reject, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule